// File: doc/BRIEF.md
# Multi-Reader Stream Buffer Monitor

This block supervises the occupancy of one circular stream buffer that is written by a single producer task and read by several consumer tasks. It does not hold the payload. It keeps one write count and one read pointer per consumer, all counted in whole datasets. It derives the fill level from the consumer that lags furthest behind, and it decides cycle by cycle whether each request to commit a dataset may proceed.

Around that bookkeeping it produces scheduling hints for a central controller. Each hint is a short event with a code and a task identifier. The level crossing into the upper threshold says the producer runs ahead, and crossing into the lower threshold says it falls behind. Both of these carry the producer's identifier. A request refused because the buffer is full or a consumer's view is empty marks that task as stalled, and the stall is reported with that task's identifier. The release of a stall is reported as well. Events wait in a short queue behind a valid/ready channel. A single pending slot per event source backs the queue, and a sticky flag records when an event had to be dropped.

Top module: `stream_buffer_monitor`

## Requirements
- R1: A producer request is accepted (wrAccept high in the same cycle) exactly when the level is below cfgCapacity, and each accepted request raises the level by one from the next cycle on.
- R2: A request from consumer i is accepted exactly when that consumer has at least one unread dataset. The level output equals the largest unread count over all consumers.
- R3: When the level moves from below cfgHighThr to at or above it, one event with code 0 and the producer's identifier is emitted. No further code 0 event is emitted while the level stays at or above it.
- R4: When the level moves from above cfgLowThr to at or below it, one event with code 1 and the producer's identifier is emitted. The two thresholds may hold the same value.
- R5: A refused producer request emits code 2 with the producer's identifier, once per stall. When the level later drops below cfgCapacity, code 3 is emitted.
- R6: A refused request from consumer i emits code 4 with readerIds[i] (identifier i occupies bits TASK_W*i upward), once per stall. When that consumer again has unread data, code 5 is emitted with the same identifier.
- R7: Events raised in one cycle leave in this priority: producer stall, consumer stalls by ascending index, code 0, code 1, producer release, consumer releases by ascending index. Stall events caused by a request leave before the threshold and release events caused by the same request.
- R8: While evValid is high and evReady is low, evValid, evCode and evTask hold their values. Each event is delivered once.
- R9: The queue holds QUEUE_DEPTH events, and one more instance per event source may wait behind it. A further instance from a source that already has one waiting is dropped and sets overflowErr, which stays high until reset.
- R10: After reset the level is 0, evValid and overflowErr are low, and no consumer or producer is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCapacity | input | LVL_W | Buffer size in datasets (1 to MAX_CAP) |
| cfgHighThr | input | LVL_W | Upper level threshold |
| cfgLowThr | input | LVL_W | Lower level threshold |
| writerId | input | TASK_W | Identifier of the producer task |
| readerIds | input | NUM_READERS*TASK_W | Consumer identifiers, consumer i in bits TASK_W*i upward |
| wrReq | input | 1 | Producer asks to commit one dataset |
| wrAccept | output | 1 | Producer commit accepted this cycle |
| rdReq | input | NUM_READERS | Consumer i asks to release one dataset |
| rdAccept | output | NUM_READERS | Consumer release accepted this cycle |
| level | output | LVL_W | Current fill level in datasets |
| evValid | output | 1 | Event available |
| evReady | input | 1 | Scheduler takes the event |
| evCode | output | 3 | Event code (0 to 5) |
| evTask | output | TASK_W | Task identifier of the event |
| overflowErr | output | 1 | Sticky event-loss flag |

## Verification
The bench builds the block with three consumers, 4-bit counts and identifiers, and a four-entry event queue. It resets into every capacity from 1 to 5 and every threshold pair with the lower threshold not above the upper one, which includes equal thresholds and thresholds at the capacity. For each configuration it runs a fixed request pattern that fills the buffer past full, drains each consumer past empty, and issues simultaneous requests that stall and release in the same cycle. A scheduler that stops taking events brings the hold behaviour and the overflow flag within reach.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  localparam int MaxReaders = 8;

  typedef enum logic [2:0] {
    EV_FAST      = 3'd0,
    EV_SLOW      = 3'd1,
    EV_WR_STALL  = 3'd2,
    EV_WR_RESUME = 3'd3,
    EV_RD_STALL  = 3'd4,
    EV_RD_RESUME = 3'd5
  } evCode_e;

  // pointer-advance strobes from control to datapath
  typedef struct packed {
    logic                  wrAdv;
    logic [MaxReaders-1:0] rdAdv;
  } ptrStrobe_t;

  // event-source slot numbering; a lower slot leaves first
  function automatic int srcWrStall();
    return 0;
  endfunction
  function automatic int srcRdStall(input int r);
    return 1 + r;
  endfunction
  function automatic int srcFast(input int n);
    return n + 1;
  endfunction
  function automatic int srcSlow(input int n);
    return n + 2;
  endfunction
  function automatic int srcWrResume(input int n);
    return n + 3;
  endfunction
  function automatic int srcRdResume(input int n, input int r);
    return n + 4 + r;
  endfunction

endpackage

// File: rtl/sbm_datapath.sv
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int NUM_READERS = 3,
  parameter int LVL_W       = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ptrStrobe_t                            ctl,
  output logic [LVL_W-1:0]                      level,
  output logic [NUM_READERS-1:0][LVL_W-1:0]     unread
);

  logic [LVL_W-1:0]                  wrCount;
  logic [NUM_READERS-1:0][LVL_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN)
      wrCount <= '0;
    else if (ctl.wrAdv)
      wrCount <= wrCount + 1'b1;
  end

  for (genvar i = 0; i < NUM_READERS; i++) begin : g_reader
    always_ff @(posedge clk) begin
      if (!rstN)
        rdPtr[i] <= '0;
      else if (ctl.rdAdv[i])
        rdPtr[i] <= rdPtr[i] + 1'b1;
    end

    assign unread[i] = wrCount - rdPtr[i];

    // R2: a consumer pointer only moves over data it has not yet read
    assert_rd_nonempty_R2: assert property (@(posedge clk) disable iff (!rstN)
      ctl.rdAdv[i] |-> unread[i] != '0);
  end

  if (NUM_READERS < MaxReaders) begin : g_spare
    logic unusedSpare;
    assign unusedSpare = ^ctl.rdAdv[MaxReaders-1:NUM_READERS];
  end

  // slowest consumer sets the level
  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_READERS; i++)
      if (unread[i] > level) level = unread[i];
  end

  // R1: a lone accepted write raises the level by exactly one
  assert_wr_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrAdv && (ctl.rdAdv == '0) |=> level == $past(level) + 1'b1);

endmodule

// File: rtl/sbm_control.sv
module sbm_control
  import sbm_pkg::*;
#(
  parameter int NUM_READERS = 3,
  parameter int LVL_W       = 4,
  parameter int NSRC        = 2 * NUM_READERS + 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [LVL_W-1:0]                  cfgCapacity,
  input  logic [LVL_W-1:0]                  cfgHighThr,
  input  logic [LVL_W-1:0]                  cfgLowThr,
  input  logic                              wrReq,
  input  logic [NUM_READERS-1:0]            rdReq,
  input  logic [LVL_W-1:0]                  level,
  input  logic [NUM_READERS-1:0][LVL_W-1:0] unread,
  output ptrStrobe_t                        ctl,
  output logic                              wrAccept,
  output logic [NUM_READERS-1:0]            rdAccept,
  output logic [NSRC-1:0]                   newEvt
);

  logic roomLeft;
  logic fastNow, slowNow, fastQ, slowQ;
  logic wrStalled, wrStallEvt, wrResumeEvt;
  logic [NUM_READERS-1:0] rdStalled, rdStallEvt, rdResumeEvt;

  assign roomLeft = level < cfgCapacity;
  assign wrAccept = wrReq && roomLeft;

  assign fastNow = level >= cfgHighThr;
  assign slowNow = level <= cfgLowThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastQ <= 1'b0;
      slowQ <= 1'b1;
    end else begin
      fastQ <= fastNow;
      slowQ <= slowNow;
    end
  end

  assign wrStallEvt  = wrReq && !roomLeft && !wrStalled;
  assign wrResumeEvt = wrStalled && roomLeft;

  always_ff @(posedge clk) begin
    if (!rstN)
      wrStalled <= 1'b0;
    else if (wrStallEvt)
      wrStalled <= 1'b1;
    else if (wrResumeEvt)
      wrStalled <= 1'b0;
  end

  for (genvar i = 0; i < NUM_READERS; i++) begin : g_reader
    logic hasData;
    assign hasData        = unread[i] != '0;
    assign rdAccept[i]    = rdReq[i] && hasData;
    assign rdStallEvt[i]  = rdReq[i] && !hasData && !rdStalled[i];
    assign rdResumeEvt[i] = rdStalled[i] && hasData;

    always_ff @(posedge clk) begin
      if (!rstN)
        rdStalled[i] <= 1'b0;
      else if (rdStallEvt[i])
        rdStalled[i] <= 1'b1;
      else if (rdResumeEvt[i])
        rdStalled[i] <= 1'b0;
    end

    // R6: a consumer stall starts only from a refused request
    assert_rd_stall_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rdStalled[i]) |-> $past(rdReq[i] && !rdAccept[i]));
  end

  always_comb begin
    ctl                           = '0;
    ctl.wrAdv                     = wrAccept;
    ctl.rdAdv[NUM_READERS-1:0]    = rdAccept;
  end

  always_comb begin
    newEvt                                 = '0;
    newEvt[srcWrStall()]                   = wrStallEvt;
    newEvt[srcFast(NUM_READERS)]           = fastNow && !fastQ;
    newEvt[srcSlow(NUM_READERS)]           = slowNow && !slowQ;
    newEvt[srcWrResume(NUM_READERS)]       = wrResumeEvt;
    for (int r = 0; r < NUM_READERS; r++) begin
      newEvt[srcRdStall(r)]                = rdStallEvt[r];
      newEvt[srcRdResume(NUM_READERS, r)]  = rdResumeEvt[r];
    end
  end

  // R5: a producer stall starts only from a refused request
  assert_wr_stall_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrStalled) |-> $past(wrReq && !wrAccept));

endmodule

// File: rtl/sbm_evqueue.sv
module sbm_evqueue
  import sbm_pkg::*;
#(
  parameter int NUM_READERS = 3,
  parameter int TASK_W      = 4,
  parameter int DEPTH       = 4,
  parameter int NSRC        = 2 * NUM_READERS + 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NSRC-1:0]                    newEvt,
  input  logic [TASK_W-1:0]                  writerId,
  input  logic [NUM_READERS-1:0][TASK_W-1:0] readerIds,
  input  logic                               evReady,
  output logic                               evValid,
  output logic [2:0]                         evCode,
  output logic [TASK_W-1:0]                  evTask,
  output logic                               overflowErr
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NSRC-1:0]   pend, grant;
  logic              full, push, pop, collide;
  logic [2:0]        pushCode;
  logic [TASK_W-1:0] pushTask;

  logic [2:0]        codeMem [DEPTH];
  logic [TASK_W-1:0] taskMem [DEPTH];
  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic [CNT_W-1:0]  count;

  assign full = count == CNT_W'(DEPTH);

  // lowest pending slot wins
  always_comb begin
    grant = '0;
    if (!full) begin
      for (int s = NSRC - 1; s >= 0; s--)
        if (pend[s]) grant = NSRC'(1) << s;
    end
  end

  always_comb begin
    pushCode = EV_FAST;
    pushTask = writerId;
    if (grant[srcWrStall()])              pushCode = EV_WR_STALL;
    if (grant[srcFast(NUM_READERS)])      pushCode = EV_FAST;
    if (grant[srcSlow(NUM_READERS)])      pushCode = EV_SLOW;
    if (grant[srcWrResume(NUM_READERS)])  pushCode = EV_WR_RESUME;
    for (int r = 0; r < NUM_READERS; r++) begin
      if (grant[srcRdStall(r)]) begin
        pushCode = EV_RD_STALL;
        pushTask = readerIds[r];
      end
      if (grant[srcRdResume(NUM_READERS, r)]) begin
        pushCode = EV_RD_RESUME;
        pushTask = readerIds[r];
      end
    end
  end

  assign push    = |grant;
  assign pop     = evValid && evReady;
  assign collide = |(newEvt & pend & ~grant);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend        <= '0;
      overflowErr <= 1'b0;
    end else begin
      pend        <= (pend & ~grant) | newEvt;
      overflowErr <= overflowErr | collide;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      codeMem[wrIdx] <= pushCode;
      taskMem[wrIdx] <= pushTask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (push)
        wrIdx <= (wrIdx == IDX_W'(DEPTH - 1)) ? '0 : wrIdx + 1'b1;
      if (pop)
        rdIdx <= (rdIdx == IDX_W'(DEPTH - 1)) ? '0 : rdIdx + 1'b1;
      if (push && !pop)
        count <= count + 1'b1;
      else if (pop && !push)
        count <= count - 1'b1;
    end
  end

  assign evValid = count != '0;
  assign evCode  = codeMem[rdIdx];
  assign evTask  = taskMem[rdIdx];

  // R8: a stalled event is held unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    evValid && !evReady |=> evValid && $stable(evCode) && $stable(evTask));

  // R9: the loss flag never clears outside reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

endmodule

// File: rtl/stream_buffer_monitor.sv
module stream_buffer_monitor
  import sbm_pkg::*;
#(
  parameter  int NUM_READERS = 3,
  parameter  int MAX_CAP     = 15,
  parameter  int TASK_W      = 4,
  parameter  int QUEUE_DEPTH = 4,
  localparam int LVL_W       = $clog2(MAX_CAP + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LVL_W-1:0]              cfgCapacity,
  input  logic [LVL_W-1:0]              cfgHighThr,
  input  logic [LVL_W-1:0]              cfgLowThr,
  input  logic [TASK_W-1:0]             writerId,
  input  logic [NUM_READERS*TASK_W-1:0] readerIds,
  input  logic                          wrReq,
  output logic                          wrAccept,
  input  logic [NUM_READERS-1:0]        rdReq,
  output logic [NUM_READERS-1:0]        rdAccept,
  output logic [LVL_W-1:0]              level,
  output logic                          evValid,
  input  logic                          evReady,
  output logic [2:0]                    evCode,
  output logic [TASK_W-1:0]             evTask,
  output logic                          overflowErr
);

  localparam int NSRC = 2 * NUM_READERS + 4;

  ptrStrobe_t                        ctl;
  logic [NUM_READERS-1:0][LVL_W-1:0] unread;
  logic [NSRC-1:0]                   newEvt;
  logic [NUM_READERS-1:0][TASK_W-1:0] readerIdArr;

  assign readerIdArr = readerIds;

  sbm_datapath #(
    .NUM_READERS(NUM_READERS),
    .LVL_W      (LVL_W)
  ) uDatapath (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .level (level),
    .unread(unread)
  );

  sbm_control #(
    .NUM_READERS(NUM_READERS),
    .LVL_W      (LVL_W),
    .NSRC       (NSRC)
  ) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCapacity(cfgCapacity),
    .cfgHighThr (cfgHighThr),
    .cfgLowThr  (cfgLowThr),
    .wrReq      (wrReq),
    .rdReq      (rdReq),
    .level      (level),
    .unread     (unread),
    .ctl        (ctl),
    .wrAccept   (wrAccept),
    .rdAccept   (rdAccept),
    .newEvt     (newEvt)
  );

  sbm_evqueue #(
    .NUM_READERS(NUM_READERS),
    .TASK_W     (TASK_W),
    .DEPTH      (QUEUE_DEPTH),
    .NSRC       (NSRC)
  ) uQueue (
    .clk        (clk),
    .rstN       (rstN),
    .newEvt     (newEvt),
    .writerId   (writerId),
    .readerIds  (readerIdArr),
    .evReady    (evReady),
    .evValid    (evValid),
    .evCode     (evCode),
    .evTask     (evTask),
    .overflowErr(overflowErr)
  );

endmodule

// File: tb/sim_stream_buffer_monitor.sv
module sim_stream_buffer_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NR         = 3;
  localparam int TW         = 4;
  localparam int LW         = 4;
  localparam int WID        = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LW-1:0] cfgCapacity = 4'd8, cfgHighThr = 4'd2, cfgLowThr = 4'd2;
  logic [TW-1:0] writerId = 4'(WID);
  logic [NR*TW-1:0] readerIds = {4'h7, 4'h5, 4'h3};
  logic wrReq = 1'b0;
  logic [NR-1:0] rdReq = '0;
  logic evReady = 1'b1;
  logic wrAccept, evValid, overflowErr;
  logic [NR-1:0] rdAccept;
  logic [LW-1:0] level;
  logic [2:0] evCode;
  logic [TW-1:0] evTask;

  int nChecks = 0, nFails = 0;
  int got[$];
  int exp[$];
  int mWr, mRd[NR];
  bit mWrSt, mRdSt[NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_buffer_monitor #(.NUM_READERS(NR), .MAX_CAP(15), .TASK_W(TW), .QUEUE_DEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .cfgCapacity(cfgCapacity), .cfgHighThr(cfgHighThr),
    .cfgLowThr(cfgLowThr), .writerId(writerId), .readerIds(readerIds),
    .wrReq(wrReq), .wrAccept(wrAccept), .rdReq(rdReq), .rdAccept(rdAccept),
    .level(level), .evValid(evValid), .evReady(evReady), .evCode(evCode),
    .evTask(evTask), .overflowErr(overflowErr));

  always @(posedge clk)
    if (rstN && evValid && evReady) got.push_back(int'({evCode, evTask}));

  function automatic int rid(input int i);
    return 3 + 2 * i;
  endfunction

  function automatic int mLevel();
    int m = 0;
    for (int i = 0; i < NR; i++) if (mWr - mRd[i] > m) m = mWr - mRd[i];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic doReset(input int cap, input int hi, input int lo);
    @(negedge clk);
    rstN = 1'b0; wrReq = 1'b0; rdReq = '0; evReady = 1'b1;
    cfgCapacity = LW'(cap); cfgHighThr = LW'(hi); cfgLowThr = LW'(lo);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mWr = 0; mWrSt = 0;
    for (int i = 0; i < NR; i++) begin mRd[i] = 0; mRdSt[i] = 0; end
    got.delete();
  endtask

  task automatic doOp(input bit wr, input bit [NR-1:0] rd);
    int lvlOld, lvlNew, cap, hi, lo;
    bit expWr;
    bit [NR-1:0] expRd;
    bit same;
    cap = int'(cfgCapacity); hi = int'(cfgHighThr); lo = int'(cfgLowThr);
    got.delete(); exp.delete();
    @(negedge clk);
    wrReq = wr; rdReq = rd;
    #1;
    lvlOld = mLevel();
    expWr = wr && (lvlOld < cap);
    for (int i = 0; i < NR; i++) expRd[i] = rd[i] && (mWr - mRd[i] > 0);
    chk(wrAccept == expWr, "R1", "wrAccept", int'(wrAccept), int'(expWr));
    chk(rdAccept == expRd, "R2", "rdAccept", int'(rdAccept), int'(expRd));
    // stall events first (R5, R6, R7)
    if (wr && !expWr && !mWrSt) begin exp.push_back(2 * 16 + WID); mWrSt = 1; end
    for (int i = 0; i < NR; i++)
      if (rd[i] && !expRd[i] && !mRdSt[i]) begin exp.push_back(4 * 16 + rid(i)); mRdSt[i] = 1; end
    if (expWr) mWr++;
    for (int i = 0; i < NR; i++) if (expRd[i]) mRd[i]++;
    lvlNew = mLevel();
    // R3 fast, R4 slow, then releases
    if (lvlNew >= hi && !(lvlOld >= hi)) exp.push_back(0 * 16 + WID);
    if (lvlNew <= lo && !(lvlOld <= lo)) exp.push_back(1 * 16 + WID);
    if (mWrSt && lvlNew < cap) begin exp.push_back(3 * 16 + WID); mWrSt = 0; end
    for (int i = 0; i < NR; i++)
      if (mRdSt[i] && mWr - mRd[i] > 0) begin exp.push_back(5 * 16 + rid(i)); mRdSt[i] = 0; end
    @(negedge clk);
    wrReq = 1'b0; rdReq = '0;
    repeat (16) @(negedge clk);
    chk(int'(level) == lvlNew, "R2", "level", int'(level), lvlNew);
    same = (got.size() == exp.size());
    for (int k = 0; k < got.size() && same; k++) same = (got[k] == exp[k]);
    chk(same, "R7", "event list (count, first code*16+task)", got.size() * 1000 + (got.size() > 0 ? got[0] : 0),
        exp.size() * 1000 + (exp.size() > 0 ? exp[0] : 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R10 reset state
    doReset(8, 2, 2);
    #1;
    chk(level == 0, "R10", "level after reset", int'(level), 0);
    chk(!evValid, "R10", "evValid after reset", int'(evValid), 0);
    chk(!overflowErr, "R10", "overflowErr after reset", int'(overflowErr), 0);
    repeat (8) @(negedge clk);
    chk(got.size() == 0, "R10", "events after reset", got.size(), 0);

    // sweep: every capacity 1..5 and threshold pair lo<=hi, hi in 1..cap
    for (int cap = 1; cap <= 5; cap++)
      for (int hi = 1; hi <= cap; hi++)
        for (int lo = 0; lo <= hi; lo++) begin
          doReset(cap, hi, lo);
          doOp(1'b0, 3'b010);
          for (int k = 0; k <= cap; k++) doOp(1'b1, 3'b000);
          for (int k = 0; k <= cap; k++) doOp(1'b0, 3'b001);
          doOp(1'b0, 3'b110);
          doOp(1'b1, 3'b111);
          for (int k = 0; k <= cap; k++) doOp(1'b0, 3'b110);
          doOp(1'b1, 3'b000);
          doOp(1'b0, 3'b111);
        end

    // R8 hold and R9 loss flag with a stalled scheduler
    doReset(8, 1, 0);
    evReady = 1'b0;
    wrReq = 1'b1; @(negedge clk); wrReq = 1'b0;
    repeat (6) @(negedge clk);
    chk(evValid == 1'b1, "R8", "evValid while stalled", int'(evValid), 1);
    chk(evCode == 3'd0 && evTask == 4'(WID), "R8", "held event", int'({evCode, evTask}), WID);
    repeat (4) @(negedge clk);
    chk(evCode == 3'd0 && evTask == 4'(WID), "R8", "event still held", int'({evCode, evTask}), WID);
    chk(!overflowErr, "R9", "no loss yet", int'(overflowErr), 0);
    for (int k = 0; k < 4; k++) begin
      rdReq = 3'b111; @(negedge clk); rdReq = '0; repeat (3) @(negedge clk);
      wrReq = 1'b1;   @(negedge clk); wrReq = 1'b0; repeat (3) @(negedge clk);
    end
    chk(overflowErr == 1'b1, "R9", "loss flag set", int'(overflowErr), 1);
    evReady = 1'b1;
    repeat (20) @(negedge clk);
    chk(overflowErr == 1'b1, "R9", "loss flag sticky", int'(overflowErr), 1);
    chk(got.size() > 0 && got[0] == WID, "R8", "first delivered event", got.size() > 0 ? got[0] : -1, WID);
    chk(!evValid, "R8", "queue drained", int'(evValid), 0);

    summary();
  end

endmodule